// File: doc/BRIEF.md
# PCIe Receive Lane Elastic Buffer

This block sits on one PCIe receive lane between the recovered receive clock and the local PHY clock. Decoded symbols enter on the write clock. Each symbol is 8 data bits plus a control flag. They leave on the read clock. The two clocks run free and may differ by a few hundred ppm. The buffer absorbs that drift by adjusting clock-compensation ordered sets only, so data symbols are never lost or repeated.

A compensation ordered set is a comma control symbol followed by skip control symbols. When the buffer runs too full, the write side drops one skip from a set. When it runs too empty, the read side repeats one skip. Each event is reported on a 3-bit receive status that travels with the affected output symbol, as are overflow and underflow. The crossing uses Gray-coded pointers through two-flop synchronizers. Reset is a single active-low asynchronous input with its own synchronizer in each clock domain.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_status` is 000. No symbol is delivered before at least START_MARK (8) symbols have been written.
- R2: When the write and read rates are within compensation range, every symbol that is not a skip leaves in write order, with its data and control flag unchanged, and `rd_status` never shows 101 or 110.
- R3: A comma is control flag 1 with data 0xBC, and a skip is control flag 1 with data 0x1C. Only skips that follow a comma within one ordered set are added or removed, and at most one is added per ordered set.
- R4: On the read side, if the last delivered symbol is a skip inside an ordered set and the read-side fill is below LO_MARK (6), that skip is delivered again with `rd_valid` 1 and `rd_status` 001.
- R5: On the write side, an eligible skip that arrives while the write-side fill is above HI_MARK (10) is discarded. The next stored symbol leaves with `rd_status` 010.
- R6: A symbol written while the buffer holds 2^AW (16) entries is discarded, and the symbols already stored are kept. The next stored symbol leaves with `rd_status` 101 and `rd_valid` 1.
- R7: When a read is due and the buffer is empty, `rd_valid` goes to 0 and `rd_data` holds the last symbol. `rd_status` is 110 for exactly one read cycle. The read side then waits until START_MARK symbols are buffered again.
- R8: A normal delivered symbol carries `rd_status` 000. `rd_valid` is 1 exactly on cycles that deliver a stored or inserted symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| rd_clk | input | 1 | Local PHY clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Write symbol present (symbol lock held) |
| wr_k | input | 1 | Write control flag, 1 = control symbol |
| wr_data | input | 8 | Write symbol data |
| rd_data | output | 8 | Delivered symbol data |
| rd_k | output | 1 | Delivered control flag |
| rd_valid | output | 1 | Delivered symbol is meaningful |
| rd_status | output | 3 | 000 ok, 001 skip added, 010 skip removed, 101 overflow, 110 underflow |

## Verification
The bench builds the block with its default parameters: a 16-entry buffer, marks at 10 and 6, and a start level of 8. At these values overflow is reached after about sixteen writes at twice the read rate. Ordered sets spaced every eight symbols can correct a 5% rate mismatch in either direction, so add and remove events both occur within a few hundred symbols. The same sizes make underflow, and the refill wait after it, observable within a few dozen read cycles of stopping the writer.

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf #(
  parameter int AW         = 4,
  parameter int HI_MARK    = 10,
  parameter int LO_MARK    = 6,
  parameter int START_MARK = 8
) (
  input  logic       wr_clk,
  input  logic       rd_clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_k,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rd_k,
  output logic       rd_valid,
  output logic [2:0] rd_status
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [7:0] SYM_SKP = 8'h1C;
  localparam logic [1:0] TAG_NONE = 2'd0, TAG_REM = 2'd1, TAG_OVF = 2'd2;
  localparam logic [2:0] ST_OK = 3'b000, ST_ADD = 3'b001, ST_REM = 3'b010,
                         ST_OVF = 3'b101, ST_UNF = 3'b110;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [1:0] wr_rs, rd_rs;
  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) wr_rs <= '0; else wr_rs <= {wr_rs[0], 1'b1};
  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) rd_rs <= '0; else rd_rs <= {rd_rs[0], 1'b1};
  wire wr_rst_n = wr_rs[1];
  wire rd_rst_n = rd_rs[1];

  logic [10:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wr_bin, wr_gray, rd_gray, rg_s1, rg_s2;
  logic          w_os, w_adj;
  logic [1:0]    w_tag;

  wire [PW-1:0] wr_fill = wr_bin - g2b(rg_s2);
  wire in_com   = wr_k && (wr_data == SYM_COM);
  wire in_skp   = wr_k && (wr_data == SYM_SKP);
  wire drop_skp = wr_valid && in_skp && w_os && !w_adj && (wr_fill > PW'(HI_MARK));
  wire full     = (wr_fill == PW'(DEPTH));
  wire push     = wr_valid && !drop_skp && !full;
  wire lost     = wr_valid && !drop_skp && full;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_bin <= '0; wr_gray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      w_os <= 1'b0; w_adj <= 1'b0; w_tag <= TAG_NONE;
    end else begin
      rg_s1 <= rd_gray;
      rg_s2 <= rg_s1;
      if (push) begin
        wr_bin  <= wr_bin + 1'b1;
        wr_gray <= b2g(wr_bin + 1'b1);
        w_tag   <= TAG_NONE;
      end
      if (lost) w_tag <= TAG_OVF;
      else if (drop_skp && w_tag != TAG_OVF) w_tag <= TAG_REM;
      if (wr_valid) begin
        if (in_com) begin w_os <= 1'b1; w_adj <= 1'b0; end
        else if (!in_skp) w_os <= 1'b0;
      end
      if (drop_skp) w_adj <= 1'b1;
    end
  end

  always_ff @(posedge wr_clk)
    if (push) mem[wr_bin[AW-1:0]] <= {w_tag, wr_k, wr_data};

  AST_FILL_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_fill <= PW'(DEPTH)); // R6

  // read domain
  logic [PW-1:0] rd_bin, wg_s1, wg_s2;
  logic          started, r_os, r_adj;

  wire [PW-1:0] rd_fill = g2b(wg_s2) - rd_bin;
  wire [10:0]   head    = mem[rd_bin[AW-1:0]];
  wire [1:0]    h_tag   = head[10:9];
  wire          h_k     = head[8];
  wire [7:0]    h_d     = head[7:0];
  wire last_skp = rd_k && (rd_data == SYM_SKP);
  wire do_ins   = started && last_skp && r_os && !r_adj && (rd_fill < PW'(LO_MARK));
  wire do_unf   = started && !do_ins && (rd_fill == '0);
  wire do_pop   = started && !do_ins && (rd_fill != '0);

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_bin <= '0; rd_gray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      started <= 1'b0; r_os <= 1'b0; r_adj <= 1'b0;
      rd_data <= '0; rd_k <= 1'b0; rd_valid <= 1'b0; rd_status <= ST_OK;
    end else begin
      wg_s1 <= wr_gray;
      wg_s2 <= wg_s1;
      rd_valid  <= 1'b0;
      rd_status <= ST_OK;
      if (!started && rd_fill >= PW'(START_MARK)) started <= 1'b1;
      if (do_ins) begin
        rd_valid  <= 1'b1;
        rd_status <= ST_ADD;
        r_adj     <= 1'b1;
      end else if (do_unf) begin
        rd_status <= ST_UNF;
        started   <= 1'b0;
      end else if (do_pop) begin
        rd_bin   <= rd_bin + 1'b1;
        rd_gray  <= b2g(rd_bin + 1'b1);
        rd_data  <= h_d;
        rd_k     <= h_k;
        rd_valid <= 1'b1;
        rd_status <= (h_tag == TAG_OVF) ? ST_OVF : (h_tag == TAG_REM) ? ST_REM : ST_OK;
        if (h_k && h_d == SYM_COM) begin r_os <= 1'b1; r_adj <= 1'b0; end
        else if (!(h_k && h_d == SYM_SKP)) r_os <= 1'b0;
      end
    end
  end

  AST_INSERT_IS_SKP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == ST_ADD |-> rd_valid && rd_k && rd_data == SYM_SKP); // R4
  AST_ONE_INSERT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == ST_ADD |=> rd_status != ST_ADD); // R3
  AST_REMOVE_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == ST_REM |-> rd_valid); // R5
  AST_OVERFLOW_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == ST_OVF |-> rd_valid); // R6
  AST_UNDERFLOW_INVALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == ST_UNF |-> !rd_valid && $stable(rd_data)); // R7
  AST_UNDERFLOW_ONCE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == ST_UNF |=> rd_status == ST_OK && !rd_valid); // R7
endmodule

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_k = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_k, rd_valid;
  logic [2:0] rd_status;
  real wr_half = 5.0;

  rx_elastic_buf u_dut (.wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_k(wr_k), .wr_data(wr_data),
    .rd_data(rd_data), .rd_k(rd_k), .rd_valid(rd_valid), .rd_status(rd_status));

  always #5 rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  // scenario: write half period in ps, symbol count, must see remove, must see add
  localparam int SCN [3][4] = '{'{5000, 400, 0, 0}, '{4750, 640, 1, 0}, '{5250, 640, 0, 1}};

  int n_tests = 0, n_fail = 0, wr_sent = 0, valid_cnt = 0;
  int seen_add = 0, seen_rem = 0, seen_ovf = 0, seen_unf = 0, bad_rate = 0, adds_in_set = 0;
  bit first_seen = 0, chk_order = 0, chk_incr = 0, stream_on = 0, done = 0;
  logic [7:0] last_incr;
  logic [8:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge rd_clk) if (rst_n && !done) begin
    if (rd_valid) valid_cnt++;
    if (rd_valid && !first_seen) begin
      first_seen = 1;
      chk(wr_sent >= 8, "R1 first output after start level", wr_sent, 8);
    end
    if (rd_valid && rd_k && rd_data == 8'hBC) adds_in_set = 0;
    if (rd_status == 3'b001) begin
      seen_add++; adds_in_set++;
      chk(rd_valid && rd_k && rd_data == 8'h1C, "R4 inserted symbol is skip", {rd_valid, rd_k, rd_data}, {2'b11, 8'h1C});
      chk(adds_in_set <= 1, "R3 one insert per set", adds_in_set, 1);
    end
    if (rd_status == 3'b010) seen_rem++;
    if (rd_status == 3'b101) begin
      seen_ovf++;
      chk(rd_valid, "R6 overflow status on valid symbol", rd_valid, 1);
    end
    if (rd_status == 3'b110) seen_unf++;
    if (stream_on && (rd_status == 3'b101 || rd_status == 3'b110)) bad_rate++;
    if (chk_order && rd_valid && !(rd_k && rd_data == 8'h1C)) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected symbol", {rd_k, rd_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({rd_k, rd_data} == e, "R2 symbol order", {rd_k, rd_data}, e);
        if (!rd_k) chk(rd_status == 3'b000 || rd_status == 3'b010, "R8 data status", rd_status, 0);
      end
    end
    if (chk_incr && rd_valid) begin
      if (valid_cnt > 1) chk(rd_data > last_incr, "R6 stored symbols kept in order", rd_data, last_incr + 1);
      last_incr = rd_data;
    end
  end

  task automatic send(input bit k, input logic [7:0] d);
    @(negedge wr_clk);
    wr_valid = 1; wr_k = k; wr_data = d; wr_sent++;
    if (!(k && d == 8'h1C)) exp_q.push_back({k, d});
  endtask

  task automatic idle_wr();
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic do_reset();
    chk_order = 0; chk_incr = 0; stream_on = 0;
    wr_valid = 0;
    rst_n = 0;
    #23;
    chk(rd_valid == 0 && rd_status == 3'b000, "R1 reset outputs", {rd_valid, rd_status}, 0);
    exp_q.delete();
    wr_sent = 0; valid_cnt = 0; first_seen = 0;
    seen_add = 0; seen_rem = 0; seen_ovf = 0; seen_unf = 0; bad_rate = 0; adds_in_set = 0;
    rst_n = 1;
    repeat (6) @(posedge rd_clk);
  endtask

  initial begin
    do_reset();
    repeat (10) @(negedge rd_clk);
    chk(valid_cnt == 0 && rd_status == 3'b000, "R1 idle with no writes", valid_cnt, 0);

    for (int s = 0; s < 3; s++) begin
      wr_half = SCN[s][0] / 1000.0;
      do_reset();
      chk_order = 1; stream_on = 1;
      for (int n = 0, c = 0; n < SCN[s][1]; n++) begin
        case (n % 8)
          0: send(1, 8'hBC);
          1, 2, 3: send(1, 8'h1C);
          default: begin send(0, 8'(c)); c++; end
        endcase
      end
      stream_on = 0;
      idle_wr();
      repeat (40) @(negedge rd_clk);
      chk(bad_rate == 0, "R2 no overflow or underflow in range", bad_rate, 0);
      chk(exp_q.size() == 0, "R2 all symbols delivered", exp_q.size(), 0);
      if (SCN[s][2] != 0) chk(seen_rem > 0, "R5 skip removed when write faster", seen_rem, 1);
      if (SCN[s][3] != 0) chk(seen_add > 0, "R4 skip added when write slower", seen_add, 1);
    end

    // overflow
    wr_half = 2.5;
    do_reset();
    chk_incr = 1;
    for (int n = 0; n < 120; n++) send(0, 8'(n));
    idle_wr();
    repeat (200) @(negedge rd_clk);
    chk(seen_ovf > 0, "R6 overflow reported", seen_ovf, 1);
    chk(valid_cnt < 120 && valid_cnt >= 16, "R6 symbols discarded on full", valid_cnt, 60);
    chk_incr = 0;

    // underflow
    wr_half = 5.0;
    do_reset();
    for (int n = 0; n < 30; n++) send(0, 8'(n));
    idle_wr();
    begin
      bit found;
      found = 0;
      for (int i = 0; i < 80 && !found; i++) begin
        @(negedge rd_clk);
        if (rd_status == 3'b110) found = 1;
      end
      chk(found, "R7 underflow status", rd_status, 6);
      chk(rd_valid == 0, "R7 valid low on underflow", rd_valid, 0);
      chk(rd_data == 8'd29, "R7 last symbol repeated", rd_data, 29);
      @(negedge rd_clk);
      chk(rd_status == 3'b000 && rd_valid == 0, "R7 status for one cycle", rd_status, 0);
    end
    begin
      int v0;
      v0 = valid_cnt;
      for (int n = 0; n < 5; n++) send(0, 8'(40 + n));
      idle_wr();
      repeat (20) @(negedge rd_clk);
      chk(valid_cnt == v0, "R7 waits for refill", valid_cnt, v0);
      for (int n = 0; n < 10; n++) send(0, 8'(50 + n));
      idle_wr();
      repeat (30) @(negedge rd_clk);
      chk(valid_cnt > v0, "R8 delivery resumes after refill", valid_cnt, v0 + 15);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge rd_clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule